// File: doc/BRIEF.md
# Trace capture ring buffer with doubleword readout

This block records a wide probe word into on-chip RAM on every clock cycle, treating the storage as a ring: the write position advances by one entry per cycle and wraps at the end of the buffer. Each entry is 256 bits wide. Software inspects what was recorded through a narrow 64-bit register window and reads back one doubleword at a time.

Two independent register windows are provided, one for the processor and one for a debug port. Each window has an address register and a data register, and both windows use the same layout. The address register reports the current write position, with the buffer size folded into the same field, and it also holds a read position and a freeze bit. Reading the data register returns the doubleword at the read position and steps that position forward. Recording stops while the freeze bit of either window is set, so the contents stay stable during readout. With a length parameter of zero, no storage and no capture logic are built.

Top module: `trace_ring`

## Requirements
- R1: While neither freeze bit is set, every rising clock edge out of reset stores `probe_i` into the entry at the write pointer, and the write pointer then advances by one, wrapping modulo DEPTH (DEPTH a power of two, at least 2).
- R2: Reading the address register (`*_sel_i` = 0) returns, on the cycle after the strobe and held until the next read: bits [63:32] = write pointer OR DEPTH, bit 31 = that window's freeze bit, bits [30:0] = that window's read pointer, zero-extended.
- R3: Reading the data register (`*_sel_i` = 1) returns, on the cycle after the strobe, doubleword (read pointer mod 4) of entry (read pointer / 4), where doubleword 0 is entry bits [63:0] and doubleword 3 is bits [255:192]; the read pointer then increases by one.
- R4: While the freeze bit of either window is set, the write pointer and the stored entries do not change.
- R5: Writing the address register loads that window's read pointer from the low bits of the written value and its freeze bit from bit 31; the write-pointer field ignores the written value.
- R6: The read pointer wraps modulo 4 × DEPTH, so a data read at the last doubleword is followed by doubleword 0 of entry 0.
- R7: The two windows keep separate read pointers and freeze bits; accesses on one window leave the other window's state unchanged.
- R8: A write strobe with `*_sel_i` = 1 (data register) has no effect, and a write strobe takes precedence over a read strobe in the same cycle.
- R9: With DEPTH = 0, the write-pointer field reads as zero and data reads return zero.
- R10: After reset both read pointers, both freeze bits, the write pointer and both read-data outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| probe_i | input | 256 | Word recorded each unfrozen cycle |
| cpu_rd_i | input | 1 | Processor window read strobe |
| cpu_wr_i | input | 1 | Processor window write strobe |
| cpu_sel_i | input | 1 | Processor window register select: 0 address, 1 data |
| cpu_wdata_i | input | 64 | Processor window write value |
| cpu_rdata_o | output | 64 | Processor window read value |
| dbg_rd_i | input | 1 | Debug window read strobe |
| dbg_wr_i | input | 1 | Debug window write strobe |
| dbg_sel_i | input | 1 | Debug window register select: 0 address, 1 data |
| dbg_wdata_i | input | 64 | Debug window write value |
| dbg_rdata_o | output | 64 | Debug window read value |

## Verification
The assertions take for granted that strobes are single-cycle pulses sampled at the rising edge and that a read and a write on the same window in one cycle resolve in favour of the write. They also rely on DEPTH being zero or a power of two, so that pointer wrap is a plain binary rollover. The stimulus drives every strobe for exactly one cycle from the falling edge, and it reads entries only while capture is frozen. It also addresses only entries that have been written since reset, so every value checked is defined.

// File: rtl/trace_pkg.sv
package trace_pkg;
    typedef enum logic {
        SEL_ADDR = 1'b0,
        SEL_DATA = 1'b1
    } reg_sel_e;

    localparam int FREEZE_BIT = 31;
    localparam int NPORTS     = 2;
endpackage

// File: rtl/trace_ram.sv
module trace_ram #(
    parameter int DEPTH   = 2048,
    parameter int ENTRY_W = 256,
    parameter int DW      = 64,
    parameter int AW      = 11,
    parameter int LB      = 2,
    parameter int RPW     = AW + LB
) (
    input  logic                          clk,
    input  logic                          we,
    input  logic [AW-1:0]                 waddr,
    input  logic [ENTRY_W-1:0]            wdata,
    input  logic [trace_pkg::NPORTS-1:0]  re,
    input  logic [trace_pkg::NPORTS-1:0][RPW-1:0] rptr,
    output logic [trace_pkg::NPORTS-1:0][DW-1:0]  dword
);
    logic [ENTRY_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    for (genvar p = 0; p < trace_pkg::NPORTS; p++) begin : g_rd
        logic [ENTRY_W-1:0] line_q;
        logic [LB-1:0]      lane_q;

        always_ff @(posedge clk) begin
            if (re[p]) begin
                line_q <= mem[rptr[p][RPW-1:LB]];
                lane_q <= rptr[p][LB-1:0];
            end
        end

        assign dword[p] = line_q[lane_q*DW +: DW];
    end
endmodule

// File: rtl/trace_regport.sv
module trace_regport #(
    parameter int DW  = 64,
    parameter int RPW = 13
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           rd_en,
    input  logic           wr_en,
    input  logic           sel,
    input  logic [DW-1:0]  wdata,
    input  logic [31:0]    wptr_field,
    input  logic [DW-1:0]  ram_dword,
    output logic           ram_re,
    output logic [RPW-1:0] rptr,
    output logic           freeze,
    output logic [DW-1:0]  rdata
);
    import trace_pkg::*;

    localparam int PADW = FREEZE_BIT - RPW;

    typedef struct packed {
        logic [RPW-1:0] rptr;
        logic           frz;
        logic [DW-1:0]  hold;
        logic           from_ram;
    } port_state_t;

    port_state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        ram_re = 1'b0;
        if (wr_en) begin
            if (reg_sel_e'(sel) == SEL_ADDR) begin
                st_d.rptr = wdata[RPW-1:0];
                st_d.frz  = wdata[FREEZE_BIT];
            end
        end else if (rd_en) begin
            if (reg_sel_e'(sel) == SEL_ADDR) begin
                st_d.hold     = {wptr_field, st_q.frz, {PADW{1'b0}}, st_q.rptr};
                st_d.from_ram = 1'b0;
            end else begin
                ram_re        = 1'b1;
                st_d.rptr     = st_q.rptr + 1'b1;
                st_d.from_ram = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rptr   = st_q.rptr;
    assign freeze = st_q.frz;
    assign rdata  = st_q.from_ram ? ram_dword : st_q.hold;
endmodule

// File: rtl/trace_ring.sv
module trace_ring #(
    parameter int DEPTH   = 2048,
    parameter int ENTRY_W = 256,
    parameter int DW      = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRY_W-1:0] probe_i,
    input  logic               cpu_rd_i,
    input  logic               cpu_wr_i,
    input  logic               cpu_sel_i,
    input  logic [DW-1:0]      cpu_wdata_i,
    output logic [DW-1:0]      cpu_rdata_o,
    input  logic               dbg_rd_i,
    input  logic               dbg_wr_i,
    input  logic               dbg_sel_i,
    input  logic [DW-1:0]      dbg_wdata_i,
    output logic [DW-1:0]      dbg_rdata_o
);
    import trace_pkg::*;

    localparam int AW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LB  = $clog2(ENTRY_W / DW);
    localparam int RPW = AW + LB;

    logic [NPORTS-1:0]          rd_v, wr_v, sel_v, re_v, frz;
    logic [NPORTS-1:0][DW-1:0]  wd_v, rd_data, dword;
    logic [NPORTS-1:0][RPW-1:0] rptr;
    logic [AW-1:0]              wptr_q, wptr_d;
    logic [31:0]                wptr_field;
    logic                       capture;

    assign rd_v  = {dbg_rd_i, cpu_rd_i};
    assign wr_v  = {dbg_wr_i, cpu_wr_i};
    assign sel_v = {dbg_sel_i, cpu_sel_i};
    assign wd_v  = {dbg_wdata_i, cpu_wdata_i};
    assign capture = (frz == '0);

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        trace_regport #(.DW(DW), .RPW(RPW)) u_port (
            .clk        (clk),
            .rst_n      (rst_n),
            .rd_en      (rd_v[p]),
            .wr_en      (wr_v[p]),
            .sel        (sel_v[p]),
            .wdata      (wd_v[p]),
            .wptr_field (wptr_field),
            .ram_dword  (dword[p]),
            .ram_re     (re_v[p]),
            .rptr       (rptr[p]),
            .freeze     (frz[p]),
            .rdata      (rd_data[p])
        );
    end

    if (DEPTH > 0) begin : g_store
        always_comb begin
            wptr_d = wptr_q;
            if (capture) wptr_d = wptr_q + 1'b1;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) wptr_q <= '0;
            else        wptr_q <= wptr_d;
        end

        assign wptr_field = 32'(DEPTH) | 32'(wptr_q);

        trace_ram #(
            .DEPTH(DEPTH), .ENTRY_W(ENTRY_W), .DW(DW),
            .AW(AW), .LB(LB), .RPW(RPW)
        ) u_ram (
            .clk   (clk),
            .we    (capture && rst_n),
            .waddr (wptr_q),
            .wdata (probe_i),
            .re    (re_v),
            .rptr  (rptr),
            .dword (dword)
        );
    end else begin : g_none
        assign wptr_d     = '0;
        assign wptr_q     = '0;
        assign wptr_field = '0;
        assign dword      = '0;
    end

    assign cpu_rdata_o = rd_data[0];
    assign dbg_rdata_o = rd_data[1];
endmodule

// File: rtl/trace_ring_chk.sv
module trace_ring_chk #(
    parameter int DEPTH = 2048,
    parameter int AW    = 11,
    parameter int RPW   = 13
) (
    input logic           clk,
    input logic           rst_n,
    input logic           cpu_rd,
    input logic           cpu_wr,
    input logic           cpu_sel,
    input logic [63:0]    cpu_wdata,
    input logic           dbg_wr,
    input logic           dbg_sel,
    input logic [AW-1:0]  wptr,
    input logic [1:0]     frz,
    input logic [RPW-1:0] rptr0,
    input logic [RPW-1:0] rptr1
);
    localparam bit HAS_STORE = (DEPTH > 0);

    assert_advance_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (HAS_STORE && frz == 2'b00) |=> wptr == AW'($past(wptr) + 1'b1));

    assert_freeze_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (frz != 2'b00) |=> $stable(wptr));

    assert_rd_inc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && !cpu_wr && cpu_sel) |=> rptr0 == RPW'($past(rptr0) + 1'b1));

    assert_addr_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && !cpu_sel) |=> (frz[0] == $past(cpu_wdata[31]))
                                 && (rptr0 == $past(cpu_wdata[RPW-1:0])));

    assert_data_wr_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_wr && dbg_sel) |=> $stable(rptr1) && $stable(frz[1]));

    assert_port_isolation_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_rd && !cpu_wr) |=> $stable(rptr0) && $stable(frz[0]));
endmodule

bind trace_ring trace_ring_chk #(.DEPTH(DEPTH), .AW(AW), .RPW(RPW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_rd    (cpu_rd_i),
    .cpu_wr    (cpu_wr_i),
    .cpu_sel   (cpu_sel_i),
    .cpu_wdata (cpu_wdata_i),
    .dbg_wr    (dbg_wr_i),
    .dbg_sel   (dbg_sel_i),
    .wptr      (wptr_q),
    .frz       (frz),
    .rptr0     (rptr[0]),
    .rptr1     (rptr[1])
);

// File: tb/trace_ring_bench.sv
module trace_ring_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;
    localparam logic [63:0] FRZ = 64'h8000_0000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [255:0] probe;
    logic         c_rd = 0, c_wr = 0, c_sel = 0, d_rd = 0, d_wr = 0, d_sel = 0;
    logic [63:0]  c_wd = '0, d_wd = '0, c_rdata, d_rdata;
    logic         z_rd = 0, z_wr = 0, z_sel = 0;
    logic [63:0]  z_wd = '0, z_rdata, z_drd;
    logic [31:0]  stamp = '0;
    int checks = 0, fails = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb
        for (int k = 0; k < 4; k++)
            probe[k*64 +: 64] = {16'hA000 + 16'(k), 16'h0, stamp};

    trace_ring #(.DEPTH(DEPTH)) u_trace_ring (
        .clk(clk), .rst_n(rst_n), .probe_i(probe),
        .cpu_rd_i(c_rd), .cpu_wr_i(c_wr), .cpu_sel_i(c_sel),
        .cpu_wdata_i(c_wd), .cpu_rdata_o(c_rdata),
        .dbg_rd_i(d_rd), .dbg_wr_i(d_wr), .dbg_sel_i(d_sel),
        .dbg_wdata_i(d_wd), .dbg_rdata_o(d_rdata)
    );

    trace_ring #(.DEPTH(0)) u_trace_ring_zero (
        .clk(clk), .rst_n(rst_n), .probe_i(probe),
        .cpu_rd_i(z_rd), .cpu_wr_i(z_wr), .cpu_sel_i(z_sel),
        .cpu_wdata_i(z_wd), .cpu_rdata_o(z_rdata),
        .dbg_rd_i(1'b0), .dbg_wr_i(1'b0), .dbg_sel_i(1'b0),
        .dbg_wdata_i(64'h0), .dbg_rdata_o(z_drd)
    );

    initial forever begin
        @(negedge clk);
        stamp = stamp + 1;
    end

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // one single-cycle register access; starts just after a falling edge
    task automatic acc(input bit dbg, input bit rd, input bit wr, input bit sel,
                       input logic [63:0] wd, output logic [63:0] q);
        if (dbg) begin d_rd = rd; d_wr = wr; d_sel = sel; d_wd = wd; end
        else     begin c_rd = rd; c_wr = wr; c_sel = sel; c_wd = wd; end
        @(negedge clk);
        c_rd = 0; c_wr = 0; d_rd = 0; d_wr = 0;
        q = dbg ? d_rdata : c_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    logic [63:0] q, v10;
    logic [31:0] s0;

    task automatic t_reset();
        chk("R10 cpu rdata", c_rdata, 64'h0);
        chk("R10 dbg rdata", d_rdata, 64'h0);
        @(negedge clk);
        rst_n = 1'b1;
        idle(5);
        acc(0, 0, 1, 0, FRZ, q);                       // 6 entries written
        acc(0, 1, 0, 0, 0, q);
        chk("R2 addr after 6 writes", q, {32'(DEPTH) | 32'd6, 32'h8000_0000});
    endtask

    task automatic t_readout();
        acc(0, 1, 0, 1, 0, q);
        s0 = q[31:0];
        chk("R3 lane0 tag", {q[63:48], q[47:32]}, {16'hA000, 16'h0});
        for (int i = 1; i < 24; i++) begin
            acc(0, 1, 0, 1, 0, q);
            chk("R3 doubleword", q, {16'hA000 + 16'(i % 4), 16'h0, s0 + 32'(i / 4)});
        end
        acc(0, 1, 0, 0, 0, q);
        chk("R3 rptr after 24 reads", q, {32'(DEPTH) | 32'd6, 32'h8000_0018});
        idle(20);
        acc(0, 1, 0, 0, 0, q);
        chk("R4 frozen wptr", q[63:32], 32'(DEPTH) | 32'd6);
    endtask

    task automatic t_dual_freeze();
        acc(1, 0, 1, 0, FRZ, q);
        acc(0, 0, 1, 0, 64'h0, q);
        idle(10);
        acc(0, 1, 0, 0, 0, q);
        chk("R4 dbg freeze holds wptr", q, {32'(DEPTH) | 32'd6, 32'h0});
        acc(1, 0, 1, 0, 64'h0, q);                     // capture resumes
        idle(20);
        acc(0, 0, 1, 0, FRZ, q);                       // 21 more writes
        acc(0, 1, 0, 0, 0, q);
        chk("R1 wptr wraps", q, {32'(DEPTH) | 32'd11, 32'h8000_0000});
    endtask

    task automatic t_ports();
        acc(1, 0, 1, 0, 64'd40, q);
        acc(1, 1, 0, 1, 0, v10);
        acc(1, 0, 1, 0, 64'd44, q);
        acc(1, 1, 0, 1, 0, q);
        chk("R1 oldest entry follows newest", q, {16'hA000, 16'h0, v10[31:0] - 32'd15});
        acc(1, 1, 0, 0, 0, q);
        chk("R7 dbg addr", q, {32'(DEPTH) | 32'd11, 32'd45});
        acc(0, 1, 0, 0, 0, q);
        chk("R7 cpu untouched", q[31:0], 32'h8000_0000);
        acc(1, 1, 1, 0, 64'd3, q);                     // write wins over read
        acc(1, 1, 0, 0, 0, q);
        chk("R8 write beats read", q[31:0], 32'd3);
        acc(1, 0, 1, 1, 64'hFFFF_FFFF_FFFF_FFFF, q);
        acc(1, 1, 0, 0, 0, q);
        chk("R8 data write ignored", q, {32'(DEPTH) | 32'd11, 32'd3});
        acc(1, 0, 1, 0, 64'hFFFF_0000_0000_0005, q);
        acc(1, 1, 0, 0, 0, q);
        chk("R5 wptr field read-only", q, {32'(DEPTH) | 32'd11, 32'd5});
    endtask

    task automatic t_wrap();
        acc(0, 0, 1, 0, FRZ | 64'd63, q);
        acc(0, 1, 0, 1, 0, q);
        chk("R6 last doubleword", q, {16'hA003, 16'h0, v10[31:0] - 32'd11});
        acc(0, 1, 0, 1, 0, q);
        chk("R6 wrap to entry 0", q, {16'hA000, 16'h0, v10[31:0] - 32'd10});
        acc(0, 1, 0, 0, 0, q);
        chk("R6 rptr after wrap", q[31:0], 32'h8000_0001);
    endtask

    task automatic t_zero();
        z_rd = 1; z_sel = 0;
        @(negedge clk); z_rd = 0;
        chk("R9 zero-depth addr", z_rdata, 64'h0);
        z_rd = 1; z_sel = 1;
        @(negedge clk); z_rd = 0;
        chk("R9 zero-depth data", z_rdata, 64'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        idle(3);
        t_reset();
        t_readout();
        t_dual_freeze();
        t_ports();
        t_wrap();
        t_zero();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule